// File: doc/BRIEF.md
# PHY Soft-Reset Sequencer

This block drives the software reset of a single Ethernet PHY through the command side of an MDIO management master. After a start request it asks the master to write the control word that raises the self-clearing reset flag in the PHY's basic control register. It then keeps reading that register back until the flag has dropped. The MDIO waveform is left to the master. This block only decides which transfer comes next and when to stop.

Each transfer is requested with a one-cycle command strobe. The master answers later with a one-cycle completion strobe, an error flag and, for reads, the returned word. Polling ends in one of three ways: the flag reads clear, a parameterised number of reads still show it set, or any transfer reports an error. In every case the block raises a one-cycle completion pulse and holds exactly one outcome flag until the next sequence ends. On the real system the PHY clears the flag within half a second, so the default poll limit is one million reads. Simulation overrides it with a small value.

Top module: `phy_rst_seq`

## Requirements
- R1: A start pulse while idle captures the PHY address. In the next cycle the block issues one command: cmd_go high for one cycle, cmd_write = 1, cmd_reg = 0 and cmd_wdata = 16'h8000, with cmd_phy equal to the captured address.
- R2: If the completion of that write carries mst_err = 1, the sequence ends with xfer_err and no read command is ever issued.
- R3: After an error-free write, the block issues a read of register 0 (cmd_write = 0, cmd_reg = 0). One cycle after each read completion that shows bit 15 = 1 and no error, it issues the next read.
- R4: A read completion with bit 15 = 0 and no error ends the sequence with ok = 1. All other bits of the returned word are ignored.
- R5: After POLL_MAX error-free reads that all show bit 15 = 1, the sequence ends with timed_out = 1 and no further read is issued.
- R6: A read completion with mst_err = 1 ends the sequence at once with xfer_err = 1, whatever the value of bit 15.
- R7: The end of a sequence is signalled by done high for exactly one cycle. This is the cycle after the deciding completion. The outcome flags ok, timed_out and xfer_err have at most one set, and they change only together with done.
- R8: A start pulse while a sequence runs is ignored, and cmd_phy keeps the first address. A completion strobe while no transfer is outstanding is ignored.
- R9: During and after reset, busy, cmd_go, done, ok, timed_out and xfer_err are all 0.
- R10: busy is high from the cycle after an accepted start through the cycle of the last completion, and is low in the cycle where done is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a reset sequence (honoured only when idle) |
| phy_addr | input | ADDR_W | Address of the PHY to reset |
| mst_done | input | 1 | Master completion strobe, one cycle |
| mst_err | input | 1 | Transfer failed; valid with mst_done |
| mst_rdata | input | DATA_W | Read word; valid with mst_done |
| cmd_go | output | 1 | One-cycle command strobe to the master |
| cmd_write | output | 1 | 1 = write, 0 = read; valid with cmd_go |
| cmd_phy | output | ADDR_W | PHY address of the command |
| cmd_reg | output | REG_W | Register address of the command (always 0) |
| cmd_wdata | output | DATA_W | Write word (16'h8000 for writes) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| ok | output | 1 | Last sequence saw the reset flag clear |
| timed_out | output | 1 | Last sequence ran out of polls |
| xfer_err | output | 1 | Last sequence ended on a transfer error |

## Verification
The bench aims at the boundary of the poll limit. A design with an off-by-one count would issue one read too many or one too few before it reports a timeout. It also covers a flag that clears on the very first read, which an off-by-one design might treat as a poll. A failing write must end the sequence with no read at all, and a design that ignored the error would go on polling. An error on a read whose word has bit 15 clear must still count as a failure; reversing the two tests would report success. Returned words have every other bit flipped, to expose a design that tests the wrong bit. A second start and stray completions while idle are also sent, which would corrupt the address or produce phantom done pulses in a design that does not gate them.

// File: rtl/phy_rst_pkg.sv
package phy_rst_pkg;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_WR_REQ  = 3'd1,
    S_WR_WAIT = 3'd2,
    S_RD_REQ  = 3'd3,
    S_RD_WAIT = 3'd4
  } seq_state_e;

  // register index of the basic control register and its self-clearing flag
  localparam int unsigned CTRL_REG_IDX = 0;
  localparam int unsigned RST_FLAG_BIT = 15;

  // word that raises only the reset flag
  function automatic logic [15:0] reset_word();
    logic [15:0] w;
    w = '0;
    w[RST_FLAG_BIT] = 1'b1;
    return w;
  endfunction

  // true while the PHY still reports reset in progress
  function automatic logic flag_still_set(input logic [15:0] rd);
    return rd[RST_FLAG_BIT];
  endfunction

  // true when a poll count, once advanced, reaches the limit
  function automatic logic polls_used_up(input int unsigned cnt_after,
                                         input int unsigned limit);
    return cnt_after >= limit;
  endfunction

endpackage

// File: rtl/rst_poll_ctr.sv
module rst_poll_ctr #(
  parameter int unsigned POLL_MAX = 1000000,
  localparam int unsigned CW = $clog2(POLL_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          incr,
  output logic [CW-1:0] count,
  output logic          at_limit
);
  import phy_rst_pkg::*;

  logic [CW-1:0] count_nxt;

  assign count_nxt = count + 1'b1;
  assign at_limit  = polls_used_up(int'(count_nxt), POLL_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (incr)  count <= count_nxt;
  end

  // R5: the count of flagged reads never runs past the limit
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= POLL_MAX);

  // R5: a poll is never counted once the limit has been reached
  p_no_incr_past_r5: assert property (@(posedge clk) disable iff (!rst_n)
    incr |-> int'(count) < POLL_MAX);

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import phy_rst_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mst_done,
  input  logic              mst_err,
  input  logic [DATA_W-1:0] mst_rdata,
  input  logic              at_limit,
  output logic              cmd_go,
  output logic              cmd_write,
  output logic              accept,
  output logic              poll_clr,
  output logic              poll_inc,
  output logic              ev_ok,
  output logic              ev_timeout,
  output logic              ev_xfer,
  output logic              wr_fail_evt,
  output logic              busy
);

  seq_state_e state, state_nxt;
  logic       still_set;

  assign still_set = flag_still_set(mst_rdata[15:0]);

  always_comb begin
    state_nxt  = state;
    cmd_go     = 1'b0;
    cmd_write  = 1'b0;
    accept     = 1'b0;
    poll_clr   = 1'b0;
    poll_inc   = 1'b0;
    ev_ok      = 1'b0;
    ev_timeout = 1'b0;
    ev_xfer    = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          accept    = 1'b1;
          poll_clr  = 1'b1;
          state_nxt = S_WR_REQ;
        end
      end
      S_WR_REQ: begin
        cmd_go    = 1'b1;
        cmd_write = 1'b1;
        state_nxt = S_WR_WAIT;
      end
      S_WR_WAIT: begin
        if (mst_done) begin
          if (mst_err) begin
            ev_xfer   = 1'b1;
            state_nxt = S_IDLE;
          end else begin
            state_nxt = S_RD_REQ;
          end
        end
      end
      S_RD_REQ: begin
        cmd_go    = 1'b1;
        state_nxt = S_RD_WAIT;
      end
      S_RD_WAIT: begin
        if (mst_done) begin
          if (mst_err) begin
            ev_xfer   = 1'b1;
            state_nxt = S_IDLE;
          end else if (!still_set) begin
            ev_ok     = 1'b1;
            state_nxt = S_IDLE;
          end else begin
            poll_inc = 1'b1;
            if (at_limit) begin
              ev_timeout = 1'b1;
              state_nxt  = S_IDLE;
            end else begin
              state_nxt = S_RD_REQ;
            end
          end
        end
      end
      default: state_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_nxt;
  end

  assign busy        = (state != S_IDLE);
  assign wr_fail_evt = (state == S_WR_WAIT) && mst_done && mst_err;

  // R1: an accepted start is followed by the reset write
  p_first_cmd_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cmd_go && cmd_write));

  // R2: a failed write returns to idle without any read
  p_no_read_after_wr_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fail_evt |=> (!cmd_go && !busy));

  // R3: commands are single-cycle strobes
  p_cmd_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> !cmd_go);

  // R6: a read error is never reported as success or timeout
  p_rd_err_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD_WAIT && mst_done && mst_err) |-> (ev_xfer && !ev_ok && !ev_timeout));

  // R8: start is only taken when idle
  p_start_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(busy));

endmodule

// File: rtl/rst_status.sv
module rst_status (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_ok,
  input  logic ev_timeout,
  input  logic ev_xfer,
  output logic done,
  output logic ok,
  output logic timed_out,
  output logic xfer_err
);

  logic any_end;
  assign any_end = ev_ok | ev_timeout | ev_xfer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      ok        <= 1'b0;
      timed_out <= 1'b0;
      xfer_err  <= 1'b0;
    end else begin
      done <= any_end;
      if (any_end) begin
        ok        <= ev_ok;
        timed_out <= ev_timeout;
        xfer_err  <= ev_xfer;
      end
    end
  end

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: at most one outcome flag
  p_outcome_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ok, timed_out, xfer_err}));

  // R7: outcome flags move only with done
  p_outcome_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({ok, timed_out, xfer_err}));

endmodule

// File: rtl/phy_rst_seq.sv
module phy_rst_seq #(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned REG_W    = 5,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned POLL_MAX = 1000000,
  localparam int unsigned CW      = $clog2(POLL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic              mst_done,
  input  logic              mst_err,
  input  logic [DATA_W-1:0] mst_rdata,
  output logic              cmd_go,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_phy,
  output logic [REG_W-1:0]  cmd_reg,
  output logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic              timed_out,
  output logic              xfer_err
);
  import phy_rst_pkg::*;

  logic          accept, poll_clr, poll_inc, at_limit;
  logic          ev_ok, ev_timeout, ev_xfer, wr_fail_evt;
  logic [CW-1:0] poll_count;
  logic [ADDR_W-1:0] addr_q;

  rst_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mst_done   (mst_done),
    .mst_err    (mst_err),
    .mst_rdata  (mst_rdata),
    .at_limit   (at_limit),
    .cmd_go     (cmd_go),
    .cmd_write  (cmd_write),
    .accept     (accept),
    .poll_clr   (poll_clr),
    .poll_inc   (poll_inc),
    .ev_ok      (ev_ok),
    .ev_timeout (ev_timeout),
    .ev_xfer    (ev_xfer),
    .wr_fail_evt(wr_fail_evt),
    .busy       (busy)
  );

  rst_poll_ctr #(.POLL_MAX(POLL_MAX)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (poll_clr),
    .incr    (poll_inc),
    .count   (poll_count),
    .at_limit(at_limit)
  );

  rst_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_ok     (ev_ok),
    .ev_timeout(ev_timeout),
    .ev_xfer   (ev_xfer),
    .done      (done),
    .ok        (ok),
    .timed_out (timed_out),
    .xfer_err  (xfer_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= phy_addr;
  end

  assign cmd_phy   = addr_q;
  assign cmd_reg   = REG_W'(CTRL_REG_IDX);
  assign cmd_wdata = cmd_write ? DATA_W'(reset_word()) : '0;

  // R8: the target address cannot change mid-sequence
  p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_phy));

  // R10: busy is low while the end pulse is shown
  p_busy_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2: a failed write ends with the transfer-error outcome
  p_wr_err_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fail_evt |=> (done && xfer_err));

  // R5: timeout is only reported after the full poll budget
  p_timeout_budget_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> (int'(poll_count) == POLL_MAX));

endmodule

// File: tb/tb_phy_rst_seq.sv
module tb_phy_rst_seq;
  localparam int LIMIT = 4;
  localparam int LAT   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic        mst_done = 1'b0;
  logic        mst_err = 1'b0;
  logic [15:0] mst_rdata = '0;
  logic        cmd_go, cmd_write, busy, done, ok, timed_out, xfer_err;
  logic [4:0]  cmd_phy, cmd_reg;
  logic [15:0] cmd_wdata;

  phy_rst_seq #(.POLL_MAX(LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .phy_addr(phy_addr),
    .mst_done(mst_done), .mst_err(mst_err), .mst_rdata(mst_rdata),
    .cmd_go(cmd_go), .cmd_write(cmd_write), .cmd_phy(cmd_phy),
    .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .ok(ok), .timed_out(timed_out), .xfer_err(xfer_err)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  bit chk_on = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // scenario knobs for the master stand-in
  bit wr_err_q = 0;
  int clear_at = -1;   // read index (1-based) from which bit 15 reads 0
  int rd_err_at = -1;  // read index that reports an error
  int rd_idx = 0;
  int pend = 0;
  bit pend_wr = 0;
  bit spur_req = 0;

  // master stand-in: answers each command LAT negedges later
  always @(negedge clk) begin
    mst_done  = 1'b0;
    mst_err   = 1'b0;
    mst_rdata = 16'h0000;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mst_done = 1'b1;
        if (pend_wr) mst_err = wr_err_q;
        else begin
          mst_err   = (rd_idx == rd_err_at);
          mst_rdata = (clear_at > 0 && rd_idx >= clear_at) ? 16'h7FFF : 16'h8000;
        end
      end
    end
    if (rst_n && cmd_go) begin
      pend    = LAT;
      pend_wr = cmd_write;
      if (!cmd_write) rd_idx++;
    end
    if (spur_req) begin
      mst_done  = 1'b1;
      mst_rdata = 16'h0000;
      spur_req  = 0;
    end
  end

  // behavioural reference
  int  m_phase = 0;  // 0 idle, 1 write issue, 2 write wait, 3 read issue, 4 read wait
  int  m_polls = 0;
  bit  m_done = 0, m_ok = 0, m_to = 0, m_xe = 0, m_xe_rd = 0;
  logic [4:0] m_addr = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_polls = 0; m_done = 0; m_ok = 0; m_to = 0; m_xe = 0; m_addr = '0;
    end else begin
      m_done = 0;
      case (m_phase)
        0: if (start) begin m_phase = 1; m_addr = phy_addr; m_polls = 0; end
        1: m_phase = 2;
        2: if (mst_done) begin
             if (mst_err) begin m_done = 1; m_ok = 0; m_to = 0; m_xe = 1; m_xe_rd = 0; m_phase = 0; end
             else m_phase = 3;
           end
        3: m_phase = 4;
        4: if (mst_done) begin
             if (mst_err) begin m_done = 1; m_ok = 0; m_to = 0; m_xe = 1; m_xe_rd = 1; m_phase = 0; end
             else if (mst_rdata[15] == 1'b0) begin m_done = 1; m_ok = 1; m_to = 0; m_xe = 0; m_phase = 0; end
             else begin
               m_polls++;
               if (m_polls >= LIMIT) begin m_done = 1; m_ok = 0; m_to = 1; m_xe = 0; m_phase = 0; end
               else m_phase = 3;
             end
           end
        default: m_phase = 0;
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (chk_on && !finished) begin
      check("R10 busy", busy, m_phase != 0);
      check(m_phase == 1 ? "R1 cmd_go" : "R3 cmd_go", cmd_go, (m_phase == 1 || m_phase == 3));
      if (m_phase == 1) begin
        check("R1 cmd_write", cmd_write, 1);
        check("R1 cmd_reg", cmd_reg, 0);
        check("R1 cmd_wdata", cmd_wdata, 16'h8000);
        check("R1 cmd_phy", cmd_phy, m_addr);
      end
      if (m_phase == 3) begin
        check("R3 cmd_write", cmd_write, 0);
        check("R3 cmd_reg", cmd_reg, 0);
        check("R3 cmd_phy", cmd_phy, m_addr);
      end
      check("R7 done", done, m_done);
      check("R4 ok", ok, m_ok);
      check("R5 timed_out", timed_out, m_to);
      check(m_xe_rd ? "R6 xfer_err" : "R2 xfer_err", xfer_err, m_xe);
    end
  end

  task automatic setup(input bit we, input int clr, input int rerr);
    wr_err_q = we; clear_at = clr; rd_err_at = rerr; rd_idx = 0;
  endtask

  task automatic kick(input logic [4:0] a);
    @(negedge clk);
    phy_addr = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    while (!m_done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 busy", busy, 0);
    check("R9 cmd_go", cmd_go, 0);
    check("R9 done", done, 0);
    check("R9 status", {ok, timed_out, xfer_err}, 3'b000);
    rst_n = 1'b1;
    chk_on = 1;
    repeat (2) @(negedge clk);

    setup(0, 3, -1); kick(5'd5);  wait_end();   // R4 after two flagged polls
    check("R4 ok after clear", ok, 1);
    setup(1, -1, -1); kick(5'd31); wait_end();  // R2 write failure
    check("R2 no reads", rd_idx, 0);
    setup(0, -1, -1); kick(5'd12); wait_end();  // R5 poll budget
    check("R5 read count", rd_idx, LIMIT);
    setup(0, 2, 2);  kick(5'd7);  wait_end();   // R6 error beats clear flag
    check("R6 read count", rd_idx, 2);
    setup(0, 1, -1); kick(5'd0);  wait_end();   // R4 first read clear
    check("R4 single read", rd_idx, 1);
    setup(0, -1, LIMIT); kick(5'd3); wait_end(); // R6 error on last poll
    check("R6 on last poll", xfer_err, 1);

    // R8: second start mid-sequence
    setup(0, 3, -1);
    kick(5'd5);
    repeat (3) @(negedge clk);
    phy_addr = 5'd9; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!m_done) begin
      if (busy) check("R8 addr kept", cmd_phy, 5'd5);
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check("R8 single sequence", rd_idx, 3);

    // R8: stray completion while idle
    spur_req = 1;
    repeat (4) @(negedge clk);
    check("R8 stray done", done, 0);
    check("R8 stray busy", busy, 0);
    check("R8 stray status", {ok, timed_out, xfer_err}, 3'b100);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule